// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's complement operands of a parameterised width and returns their full double-width signed product. It spends one clock per operand bit. Each step looks at the lowest bit of the shifting multiplier together with one extension bit just below it. From that pair it chooses to subtract the multiplicand, add it, or do neither. It then shifts the whole accumulator, multiplier and extension chain right by one place, keeping the sign.

The caller presents both operands with a one-cycle `start` pulse while the block is idle. `busy` is raised for exactly `WIDTH` cycles. `done` pulses for one cycle as `busy` falls. The product then stays on `product` until the next accepted start. A start that arrives while a multiplication is running is dropped. The asynchronous active-low reset is released into the block through a two-stage synchroniser, so the first usable clock edge comes two cycles after `rst_n` rises.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is applied, and afterwards until the first accepted start, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures `mcand` and `mplr`, clears the accumulator and the extension bit, and sets `busy` to 1 from the next cycle.
- R3: `done` is high for exactly one cycle, WIDTH clock edges after the edge that accepted the start. `busy` falls on that same edge and never stays high longer.
- R4: `product` at `done` equals the signed product of `mcand` and `mplr`, with both read as two's complement, given as a 2*WIDTH-bit two's complement value.
- R5: With WIDTH=4, the pairs 6 times -1 and 3 times -2 both give 8'b11111010.
- R6: The most negative operand is handled in full. At WIDTH=8, -128 times -128 gives 16'h4000 and -128 times 127 gives 16'hC080.
- R7: A `start` pulse received while `busy` is 1 has no effect: the running result is the product of the operands captured first.
- R8: After `done`, `product` holds its value on every cycle until the next accepted start.
- R9: Per step, multiplier-bit pair 10 (current LSB 1, extension 0) subtracts the multiplicand, pair 01 adds it, and pairs 00 and 11 only shift. For this reason, a multiplier of all ones (-1) or zero yields the negated multiplicand or zero respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplr | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The assertions assume that `start` is a clean synchronous level sampled at rising edges. They also assume that `mcand` and `mplr` are valid in the cycle that `start` is accepted, and make no assumption about them at other times. The stimulus changes every input only at falling edges and keeps `start` high for a single cycle. It deliberately raises `start` in the middle of a running multiplication with different operand values, so the property that the stored multiplicand stays frozen while busy is exercised. Operands are drawn from seeded random values across the whole signed range, plus the extremes.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10
  } booth_op_e;
endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      q_lsb,
  input  logic      q_ext,
  output booth_op_e op
);
  // R9: pair selection of the per-step action
  always_comb begin
    unique case ({q_lsb, q_ext})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mult,
  input  booth_op_e    op,
  output logic [W-1:0] res
);
  logic         do_sub;
  logic [W-1:0] operand;
  logic [W-1:0] summed;

  always_comb begin
    do_sub  = (op == OP_SUB);
    operand = do_sub ? ~mult : mult;
    summed  = acc + operand + {{(W-1){1'b0}}, do_sub};
    res     = (op == OP_HOLD) ? acc : summed;
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8,
  localparam int CW   = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic busy,
  output logic done
);
  localparam logic [CW-1:0] STEPS = CW'(WIDTH);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          last_step;

  always_comb begin
    load_en   = start && !busy_q;
    step_en   = busy_q;
    last_step = step_en && (cnt_q == ONE);
    cnt_d     = cnt_q;
    busy_d    = busy_q;
    if (load_en) begin
      cnt_d  = STEPS;
      busy_d = 1'b1;
    end else if (step_en) begin
      cnt_d  = cnt_q - ONE;
      busy_d = !last_step;
    end
    done_d = last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load_en || step_en) cnt_q <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PW   = 2 * WIDTH,
  localparam int AW   = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplr,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    product
);
  logic             rst_sync_n;
  logic             load_en, step_en;
  booth_op_e        step_op;
  logic [AW-1:0]    acc_q, acc_d, acc_sum;
  logic [WIDTH-1:0] q_q, q_d;
  logic             qm1_q, qm1_d;
  logic [WIDTH-1:0] m_q, m_d;
  logic [AW-1:0]    m_ext;

  booth_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .load_en (load_en),
    .step_en (step_en),
    .busy    (busy),
    .done    (done)
  );

  booth_recoder u_rec (
    .q_lsb (q_q[0]),
    .q_ext (qm1_q),
    .op    (step_op)
  );

  assign m_ext = {m_q[WIDTH-1], m_q};

  booth_addsub #(.W(AW)) u_add (
    .acc  (acc_q),
    .mult (m_ext),
    .op   (step_op),
    .res  (acc_sum)
  );

  // next-state: load on accepted start, else arithmetic shift of acc:q:qm1
  always_comb begin
    acc_d = acc_q;
    q_d   = q_q;
    qm1_d = qm1_q;
    m_d   = m_q;
    if (load_en) begin
      acc_d = '0;
      q_d   = mplr;
      qm1_d = 1'b0;
      m_d   = mcand;
    end else if (step_en) begin
      acc_d = {acc_sum[AW-1], acc_sum[AW-1:1]};
      q_d   = {acc_sum[0], q_q[WIDTH-1:1]};
      qm1_d = q_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      q_q   <= '0;
      qm1_q <= 1'b0;
      m_q   <= '0;
    end else begin
      if (load_en || step_en) begin
        acc_q <= acc_d;
        q_q   <= q_d;
        qm1_q <= qm1_d;
      end
      if (load_en) m_q <= m_d;
    end
  end

  assign product = {acc_q[WIDTH-1:0], q_q};

  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy) |=> (busy && acc_q == '0 && !qm1_q && q_q == $past(mplr)));
  p_mcand_frozen_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> $stable(m_q));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !start) |=> $stable(product));
  p_guard_agrees_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (acc_q[AW-1] == acc_q[WIDTH-1]));
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (!busy && !done && product == '0));
endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mc = '0, mp = '0;
  logic        busy, done;
  logic [15:0] product;
  logic        start4 = 1'b0;
  logic [3:0]  mc4 = '0, mp4 = '0;
  logic        busy4, done4;
  logic [7:0]  product4;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  booth_seq_mult #(.WIDTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mc), .mplr(mp),
    .busy(busy), .done(done), .product(product));

  booth_seq_mult #(.WIDTH(4)) uut4 (
    .clk(clk), .rst_n(rst_n), .start(start4), .mcand(mc4), .mplr(mp4),
    .busy(busy4), .done(done4), .product(product4));

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] x, y;
    x = 16'(signed'(a));
    y = 16'(signed'(b));
    return 16'(x * y);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b,
                      input string tag, input bit inject);
    logic [15:0] exp;
    bit          early;
    exp   = ref_mul(a, b);
    early = 1'b0;
    @(negedge clk);
    start = 1'b1; mc = a; mp = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
    for (int i = 1; i <= 8; i++) begin
      if (inject && i == 3) begin
        start = 1'b1; mc = ~a; mp = b ^ 8'h5A;
      end
      @(negedge clk);
      start = 1'b0;
      if (i < 8 && (done !== 1'b0 || busy !== 1'b1)) early = 1'b1;
    end
    chk(!early, "R3", "early done or busy drop", 32'(early), 32'd0);
    chk(done === 1'b1 && busy === 1'b0, "R3", "done/busy at step count",
        {30'd0, done, busy}, 32'd2);
    chk(product === exp, tag, "product", 32'(product), 32'(exp));
    @(negedge clk);
    chk(done === 1'b0, "R3", "done one cycle", 32'(done), 32'd0);
    repeat (2) @(negedge clk);
    chk(product === exp, "R8", "product held", 32'(product), 32'(exp));
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [7:0] exp);
    @(negedge clk);
    start4 = 1'b1; mc4 = a; mp4 = b;
    @(negedge clk);
    start4 = 1'b0;
    repeat (4) @(negedge clk);
    chk(done4 === 1'b1, "R5", "done at width 4", 32'(done4), 32'd1);
    chk(product4 === exp, "R5", "4-bit product", 32'(product4), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rb;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", {30'd0, busy, done}, 32'd0);
    chk(product === 16'd0, "R1", "product in reset", 32'(product), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && product === 16'd0, "R1", "idle after reset",
        32'(product), 32'd0);

    // R5: 4-bit worked examples
    run4(4'd6, 4'b1111, 8'b11111010);
    run4(4'd3, 4'b1110, 8'b11111010);

    // R6: most negative operand
    run8(8'h80, 8'h80, "R6", 1'b0);
    chk(product === 16'h4000, "R6", "-128*-128", 32'(product), 32'h4000);
    run8(8'h80, 8'h7F, "R6", 1'b0);
    chk(product === 16'hC080, "R6", "-128*127", 32'(product), 32'hC080);
    run8(8'h7F, 8'h80, "R6", 1'b0);

    // R9: multiplier all ones / zero / alternating runs
    run8(8'd37, 8'hFF, "R9", 1'b0);
    run8(8'hC3, 8'h00, "R9", 1'b0);
    run8(8'h5B, 8'h55, "R9", 1'b0);
    run8(8'hA6, 8'h3C, "R9", 1'b0);

    // R7: start while busy ignored
    run8(8'd19, 8'hF3, "R7", 1'b1);
    run8(8'h80, 8'h81, "R7", 1'b1);

    // R4: random operands
    for (int k = 0; k < 40; k++) begin
      ra = 8'($urandom);
      rb = 8'($urandom);
      run8(ra, rb, "R4", (k % 7) == 0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule